// File: doc/BRIEF.md
# Page-Write Buffer and Self-Timed Write Sequencer

This block sits between a serial memory's bus controller and its storage array. The controller first loads a byte address. It then hands over data bytes one at a time. The block stores each byte in a page buffer, at a slot taken from an internal offset counter. That counter wraps inside the page. When the controller reports a stop, the block checks the write-protect input. If the page may be written, it runs a self-timed program cycle. The cycle streams every loaded slot into the array and then holds busy until a fixed number of clock cycles has elapsed.

While busy is high, the controller withholds acknowledges from new selections. This lets a host poll for the end of a write. A start that arrives before the stop throws the loaded bytes away. The standby flag is high whenever the block is neither collecting nor programming.

State machine (`pw_state_t`):
- **ST_IDLE**: the standby state.
- **ST_LOAD**: bytes are being collected.
- **ST_PROGRAM**: buffer slots are streamed to the array, one per cycle.
- **ST_SETTLE**: the rest of the write time is waited out.

Transitions:
- **IDLE→LOAD**: on an address load.
- **LOAD→LOAD**: on an address reload or a byte write.
- **LOAD→IDLE**: on abort, on a commit with no bytes loaded, or on a commit to a protected page. The buffer is cleared in each case.
- **LOAD→PROGRAM**: on a commit with data loaded and the page writable.
- **PROGRAM→SETTLE**: after the last slot.
- **SETTLE→IDLE**: when the write timer expires. This clears the buffer.

Top module: `eeprom_page_writer`

## Requirements
- R1: After reset, busy is 0, standby is 1 and arr_we is 0.
- R2: An addr_load pulse sets the page to wr_addr[ADDR_W-1:5] and the slot offset to wr_addr[4:0]. Each byte_wr stores wr_data at the current offset and advances the offset by one.
- R3: The offset wraps from 31 to 0 within the same page. A later byte sent to a slot replaces the earlier one, and no other page is touched.
- R4: A commit with at least one byte loaded, on a page that may be written, raises busy in the next cycle. Busy then stays high for exactly WRITE_CYCLES cycles and clears by itself.
- R5: Only the slots loaded since the last clear are written to the array, and always in the page that was addressed. Slots that were not loaded keep their old contents. arr_we is high only while busy is high.
- R6: With PROTECT_TOP_QUARTER=0 and wp=1 at the commit, the write is discarded. No array location changes and busy stays 0.
- R7: With PROTECT_TOP_QUARTER=1 and wp=1, only pages whose two top address bits are 11 are blocked. All other pages are written normally.
- R8: An abort pulse during loading discards the buffer. A commit that follows it writes nothing.
- R9: While busy is high, addr_load, byte_wr, commit and abort have no effect. They neither change the array nor lengthen busy, and nothing they carry is written afterwards.
- R10: standby is 1 in each of these cases: after reset, after a commit that starts no write, after an abort, and after a write completes. It is 0 while bytes are being loaded and while busy is high.
- R11: A commit after an address load with no byte written starts no write and leaves busy at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr_load | input | 1 | Load page and slot offset from wr_addr |
| wr_addr | input | ADDR_W | Byte address from the bus controller |
| byte_wr | input | 1 | Store wr_data at the current offset |
| wr_data | input | DATA_W | Data byte |
| commit | input | 1 | Stop seen: start the page write |
| abort | input | 1 | Start seen before stop: drop loaded bytes |
| wp | input | 1 | Write-protect pin level |
| arr_we | output | 1 | Array write enable |
| arr_addr | output | ADDR_W | Array write address |
| arr_wdata | output | DATA_W | Array write data |
| busy | output | 1 | Internal write cycle running |
| standby | output | 1 | Block idle |

## Verification
The bench builds two copies of the block from one shared stimulus. The first uses whole-array protection and WRITE_CYCLES=40. The second uses top-quarter protection and WRITE_CYCLES=45. Because the two busy lengths differ, an off-by-one in the timer shows up in both counts. Driving each copy with the same wp level and page address separates the two protection rules: a page in the top quarter and a page below it give opposite outcomes between the copies. With the default 12-bit address, the whole 4K array can be compared against a shadow copy after every operation.

// File: rtl/eeprom_pw_pkg.sv
package eeprom_pw_pkg;
    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_LOAD    = 2'd1,
        ST_PROGRAM = 2'd2,
        ST_SETTLE  = 2'd3
    } pw_state_t;
endpackage

// File: rtl/pw_page_buffer.sv
module pw_page_buffer #(
    parameter int PAGE_BYTES = 32,
    parameter int DATA_W     = 8,
    localparam int OFS_W     = $clog2(PAGE_BYTES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              wr_en,
    input  logic [OFS_W-1:0]  wr_slot,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [OFS_W-1:0]  rd_slot,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid,
    output logic              any_valid
);
    logic [DATA_W-1:0]     slot_q [PAGE_BYTES];
    logic [PAGE_BYTES-1:0] loaded_q;

    always_ff @(posedge clk) begin
        if (wr_en) begin
            slot_q[wr_slot] <= wr_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            loaded_q <= '0;
        end else if (clear) begin
            loaded_q <= '0;
        end else if (wr_en) begin
            loaded_q[wr_slot] <= 1'b1;
        end
    end

    assign rd_data   = slot_q[rd_slot];
    assign rd_valid  = loaded_q[rd_slot];
    assign any_valid = |loaded_q;
endmodule

// File: rtl/pw_protect_gate.sv
module pw_protect_gate #(
    parameter bit PROTECT_TOP_QUARTER = 1'b0
) (
    input  logic       wp,
    input  logic [1:0] page_top,
    output logic       blocked
);
    localparam logic WHOLE_ARRAY = (PROTECT_TOP_QUARTER == 1'b0);

    logic in_top_quarter;
    assign in_top_quarter = &page_top;
    assign blocked        = wp & (in_top_quarter | WHOLE_ARRAY);
endmodule

// File: rtl/pw_write_timer.sv
module pw_write_timer #(
    parameter int LIMIT = 48,
    localparam int CNT_W = $clog2(LIMIT)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             run,
    output logic [CNT_W-1:0] count,
    output logic             done
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count <= '0;
        end else if (start) begin
            count <= '0;
        end else if (run) begin
            count <= count + 1'b1;
        end
    end

    assign done = (count == CNT_W'(LIMIT - 1));
endmodule

// File: rtl/eeprom_page_writer.sv
module eeprom_page_writer
    import eeprom_pw_pkg::*;
#(
    parameter int ADDR_W              = 12,
    parameter int DATA_W              = 8,
    parameter int PAGE_BYTES          = 32,
    parameter int WRITE_CYCLES        = 48,
    parameter bit PROTECT_TOP_QUARTER = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              addr_load,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic              byte_wr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              commit,
    input  logic              abort,
    input  logic              wp,
    output logic              arr_we,
    output logic [ADDR_W-1:0] arr_addr,
    output logic [DATA_W-1:0] arr_wdata,
    output logic              busy,
    output logic              standby
);
    localparam int OFS_W  = $clog2(PAGE_BYTES);
    localparam int PAGE_W = ADDR_W - OFS_W;
    localparam int CNT_W  = $clog2(WRITE_CYCLES);

    pw_state_t          state_q, state_d;
    logic [PAGE_W-1:0]  page_q;
    logic [OFS_W-1:0]   ptr_q;

    logic               buf_clear, buf_we, any_valid, rd_valid, blocked;
    logic [DATA_W-1:0]  rd_data;
    logic               tmr_start, tmr_run, tmr_done, last_slot, go_write;
    logic [CNT_W-1:0]   tmr_count;
    logic               accepting;

    pw_page_buffer #(.PAGE_BYTES(PAGE_BYTES), .DATA_W(DATA_W)) u_buf (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (buf_clear),
        .wr_en     (buf_we),
        .wr_slot   (ptr_q),
        .wr_data   (wr_data),
        .rd_slot   (tmr_count[OFS_W-1:0]),
        .rd_data   (rd_data),
        .rd_valid  (rd_valid),
        .any_valid (any_valid)
    );

    pw_protect_gate #(.PROTECT_TOP_QUARTER(PROTECT_TOP_QUARTER)) u_gate (
        .wp       (wp),
        .page_top (page_q[PAGE_W-1:PAGE_W-2]),
        .blocked  (blocked)
    );

    pw_write_timer #(.LIMIT(WRITE_CYCLES)) u_tmr (
        .clk   (clk),
        .rst_n (rst_n),
        .start (tmr_start),
        .run   (tmr_run),
        .count (tmr_count),
        .done  (tmr_done)
    );

    assign go_write  = commit && any_valid && !blocked;
    assign last_slot = (tmr_count == CNT_W'(PAGE_BYTES - 1));
    assign accepting = (state_q == ST_IDLE) || (state_q == ST_LOAD);

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (addr_load) state_d = ST_LOAD;
            end
            ST_LOAD: begin
                if (abort)         state_d = ST_IDLE;
                else if (go_write) state_d = ST_PROGRAM;
                else if (commit)   state_d = ST_IDLE;
            end
            ST_PROGRAM: begin
                if (last_slot) state_d = ST_SETTLE;
            end
            ST_SETTLE: begin
                if (tmr_done) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Address counter: page latch plus wrapping slot offset
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            page_q <= '0;
            ptr_q  <= '0;
        end else if (accepting && addr_load) begin
            page_q <= wr_addr[ADDR_W-1:OFS_W];
            ptr_q  <= wr_addr[OFS_W-1:0];
        end else if (buf_we) begin
            ptr_q  <= ptr_q + 1'b1;
        end
    end

    // Output and control decode
    always_comb begin
        busy      = 1'b0;
        standby   = 1'b0;
        arr_we    = 1'b0;
        buf_we    = 1'b0;
        buf_clear = 1'b0;
        tmr_start = 1'b0;
        tmr_run   = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                standby = 1'b1;
            end
            ST_LOAD: begin
                buf_we    = byte_wr && !addr_load && !abort && !commit;
                buf_clear = abort || (commit && !go_write);
                tmr_start = go_write && !abort;
            end
            ST_PROGRAM: begin
                busy    = 1'b1;
                tmr_run = 1'b1;
                arr_we  = rd_valid;
            end
            ST_SETTLE: begin
                busy      = 1'b1;
                tmr_run   = 1'b1;
                buf_clear = tmr_done;
            end
            default: standby = 1'b1;
        endcase
    end

    assign arr_addr  = {page_q, tmr_count[OFS_W-1:0]};
    assign arr_wdata = rd_data;
endmodule

// File: rtl/pw_checker.sv
module pw_checker #(
    parameter int ADDR_W       = 12,
    parameter int PAGE_BYTES   = 32,
    parameter int WRITE_CYCLES = 48
) (
    input logic              clk,
    input logic              rst_n,
    input logic              commit,
    input logic              arr_we,
    input logic [ADDR_W-1:0] arr_addr,
    input logic              busy,
    input logic              standby
);
    localparam int OFS_W = $clog2(PAGE_BYTES);

    logic [31:0] run_len;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    run_len <= '0;
        else if (busy) run_len <= run_len + 1;
        else           run_len <= '0;
    end

    assert_reset_quiet_R1: assert property (@(posedge clk)
        !rst_n |-> (!busy && !arr_we && standby));

    assert_rise_needs_commit_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(commit));

    assert_busy_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (run_len < 32'(WRITE_CYCLES)));

    assert_busy_full_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (run_len == 32'(WRITE_CYCLES)));

    assert_we_in_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
        arr_we |-> busy);

    assert_page_stable_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(arr_addr[ADDR_W-1:OFS_W]));

    assert_standby_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy && standby));
endmodule

bind eeprom_page_writer pw_checker #(
    .ADDR_W       (ADDR_W),
    .PAGE_BYTES   (PAGE_BYTES),
    .WRITE_CYCLES (WRITE_CYCLES)
) u_pw_checker (
    .clk      (clk),
    .rst_n    (rst_n),
    .commit   (commit),
    .arr_we   (arr_we),
    .arr_addr (arr_addr),
    .busy     (busy),
    .standby  (standby)
);

// File: tb/eeprom_page_writer_tb.sv
module eeprom_page_writer_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int AW   = 12;
    localparam int WC_F = 40;
    localparam int WC_Q = 45;
    localparam int MEMN = 1 << AW;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic addr_load = 1'b0, byte_wr = 1'b0, commit = 1'b0, abort = 1'b0, wp = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [7:0]    wr_data = '0;

    logic          we_f, we_q, busy_f, busy_q, sb_f, sb_q;
    logic [AW-1:0] addr_f, addr_q;
    logic [7:0]    wd_f, wd_q;

    logic [7:0] mem_f [MEMN];
    logic [7:0] mem_q [MEMN];
    logic [7:0] exp_f [MEMN];
    logic [7:0] exp_q [MEMN];

    int checks = 0;
    int failures = 0;
    int cyc = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    eeprom_page_writer #(.ADDR_W(AW), .WRITE_CYCLES(WC_F), .PROTECT_TOP_QUARTER(1'b0)) dut_i (
        .clk(clk), .rst_n(rst_n), .addr_load(addr_load), .wr_addr(wr_addr),
        .byte_wr(byte_wr), .wr_data(wr_data), .commit(commit), .abort(abort), .wp(wp),
        .arr_we(we_f), .arr_addr(addr_f), .arr_wdata(wd_f), .busy(busy_f), .standby(sb_f));

    eeprom_page_writer #(.ADDR_W(AW), .WRITE_CYCLES(WC_Q), .PROTECT_TOP_QUARTER(1'b1)) dut_q (
        .clk(clk), .rst_n(rst_n), .addr_load(addr_load), .wr_addr(wr_addr),
        .byte_wr(byte_wr), .wr_data(wr_data), .commit(commit), .abort(abort), .wp(wp),
        .arr_we(we_q), .arr_addr(addr_q), .arr_wdata(wd_q), .busy(busy_q), .standby(sb_q));

    always @(posedge clk) begin
        if (we_f) mem_f[addr_f] <= wd_f;
        if (we_q) mem_q[addr_q] <= wd_q;
    end

    // {addr[11:0], nbytes[5:0], seed[7:0], wp, writes_in_full_mode, writes_in_quarter_mode}
    localparam logic [28:0] VECS [0:5] = '{
        {12'h003, 6'd5,  8'h10, 1'b0, 1'b1, 1'b1},   // R2 plain page write
        {12'h7FC, 6'd10, 8'h40, 1'b0, 1'b1, 1'b1},   // R3 wrap 28..31,0..5
        {12'hC20, 6'd4,  8'h80, 1'b1, 1'b0, 1'b0},   // R6 R7 top quarter blocked in both
        {12'h420, 6'd6,  8'hA0, 1'b1, 1'b0, 1'b1},   // R6 blocked, R7 allowed
        {12'h100, 6'd34, 8'h01, 1'b0, 1'b1, 1'b1},   // R3 overwrite after wrap
        {12'hFE0, 6'd32, 8'hC0, 1'b0, 1'b1, 1'b1}    // R5 full page, top page, no wp
    };

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic check_mem(input string tag);
        int bad_f = 0;
        int bad_q = 0;
        for (int k = 0; k < MEMN; k++) begin
            if (mem_f[k] !== exp_f[k]) bad_f++;
            if (mem_q[k] !== exp_q[k]) bad_q++;
        end
        chk(bad_f == 0, {tag, " array(full)"}, bad_f, 0);
        chk(bad_q == 0, {tag, " array(quarter)"}, bad_q, 0);
    endtask

    // Counts busy samples starting at the current negedge, after the commit edge.
    task automatic count_busy(output int nf, output int nq);
        nf = 0;
        nq = 0;
        for (int k = 0; k < 100; k++) begin
            if (busy_f) nf++;
            if (busy_q) nq++;
            @(negedge clk);
        end
    endtask

    task automatic do_page(input logic [AW-1:0] a, input int n, input logic [7:0] seed,
                           input logic w, input logic ef, input logic eq, input string tag);
        logic [7:0] sd [32];
        logic       sv [32];
        int nf, nq;
        for (int k = 0; k < 32; k++) begin sd[k] = '0; sv[k] = 1'b0; end
        @(negedge clk);
        wp = w; addr_load = 1'b1; wr_addr = a;
        @(negedge clk);
        addr_load = 1'b0;
        for (int k = 0; k < n; k++) begin
            int slot;
            slot = (int'(a[4:0]) + k) % 32;
            byte_wr = 1'b1;
            wr_data = seed + 8'(k);
            sd[slot] = wr_data;
            sv[slot] = 1'b1;
            @(negedge clk);
        end
        byte_wr = 1'b0;
        commit = 1'b1;
        @(negedge clk);
        commit = 1'b0;
        count_busy(nf, nq);
        wp = 1'b0;
        for (int k = 0; k < 32; k++) begin
            if (sv[k]) begin
                if (ef) exp_f[{a[AW-1:5], 5'(k)}] = sd[k];
                if (eq) exp_q[{a[AW-1:5], 5'(k)}] = sd[k];
            end
        end
        chk(nf == (ef ? WC_F : 0), {tag, " busy(full)"}, nf, ef ? WC_F : 0);
        chk(nq == (eq ? WC_Q : 0), {tag, " busy(quarter)"}, nq, eq ? WC_Q : 0);
        check_mem(tag);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 50000 && !finished) begin
            failures++;
            checks++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 50000);
            finish_run();
        end
    end

    initial begin
        int nf, nq;
        for (int k = 0; k < MEMN; k++) begin
            mem_f[k] = '0; mem_q[k] = '0; exp_f[k] = '0; exp_q[k] = '0;
        end
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(!busy_f && !busy_q, "R1 busy after reset", int'(busy_f), 0);
        chk(sb_f && sb_q, "R1 standby after reset", int'(sb_f), 1);
        chk(!we_f && !we_q, "R1 arr_we after reset", int'(we_f), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // Vector table walk
        for (int v = 0; v < 6; v++) begin
            do_page(VECS[v][28:17], int'(VECS[v][16:11]), VECS[v][10:3],
                    VECS[v][2], VECS[v][1], VECS[v][0], $sformatf("R2 R3 R5 R6 R7 vec%0d", v));
        end

        // R8 abort discards loaded bytes; R10 standby low while loading
        @(negedge clk);
        addr_load = 1'b1; wr_addr = 12'h200;
        @(negedge clk);
        addr_load = 1'b0; byte_wr = 1'b1; wr_data = 8'h5A;
        @(negedge clk);
        byte_wr = 1'b0;
        chk(!sb_f && !sb_q, "R10 standby while loading", int'(sb_f), 0);
        abort = 1'b1;
        @(negedge clk);
        abort = 1'b0;
        chk(sb_f && sb_q, "R10 standby after abort", int'(sb_f), 1);
        commit = 1'b1;
        @(negedge clk);
        commit = 1'b0;
        count_busy(nf, nq);
        chk(nf == 0 && nq == 0, "R8 no busy after abort", nf + nq, 0);
        check_mem("R8 abort");

        // R11 commit with no byte loaded
        addr_load = 1'b1; wr_addr = 12'h300;
        @(negedge clk);
        addr_load = 1'b0; commit = 1'b1;
        @(negedge clk);
        commit = 1'b0;
        chk(sb_f && sb_q, "R10 standby after empty commit", int'(sb_f), 1);
        count_busy(nf, nq);
        chk(nf == 0 && nq == 0, "R11 no busy on empty commit", nf + nq, 0);

        // R9 inputs ignored while busy
        addr_load = 1'b1; wr_addr = 12'h040;
        @(negedge clk);
        addr_load = 1'b0; byte_wr = 1'b1; wr_data = 8'h55;
        @(negedge clk);
        wr_data = 8'h56;
        @(negedge clk);
        byte_wr = 1'b0; commit = 1'b1;
        @(negedge clk);
        commit = 1'b0;
        exp_f[12'h040] = 8'h55; exp_f[12'h041] = 8'h56;
        exp_q[12'h040] = 8'h55; exp_q[12'h041] = 8'h56;
        nf = 0; nq = 0;
        for (int k = 0; k < 100; k++) begin
            if (busy_f) nf++;
            if (busy_q) nq++;
            if (k == 3) begin addr_load = 1'b1; wr_addr = 12'h060; end
            else if (k == 4) begin addr_load = 1'b0; byte_wr = 1'b1; wr_data = 8'h99; end
            else if (k == 5) begin byte_wr = 1'b0; commit = 1'b1; end
            else if (k == 6) begin commit = 1'b0; abort = 1'b1; end
            else if (k == 7) abort = 1'b0;
            @(negedge clk);
        end
        chk(nf == WC_F, "R9 busy length unchanged (full)", nf, WC_F);
        chk(nq == WC_Q, "R9 busy length unchanged (quarter)", nq, WC_Q);
        chk(sb_f && sb_q, "R10 standby after write completes", int'(sb_q), 1);
        commit = 1'b1;
        @(negedge clk);
        commit = 1'b0;
        count_busy(nf, nq);
        chk(nf == 0 && nq == 0, "R9 nothing queued during busy", nf + nq, 0);
        check_mem("R9 busy ignore");

        finish_run();
    end
endmodule